// File: doc/BRIEF.md
# Signature Clause Literal Encoder

This block converts a text signature, delivered one character per transfer, into three-literal constraint clauses over a fixed set of fourteen Boolean variables. These clauses can be appended to a satisfiability instance so that any solution of the enlarged instance also carries the signature. The encoding does not depend on letter case. Each letter selects one variable and chooses its plain or complemented form. The space character selects the fourteenth variable. Any other character is discarded and sets a sticky error flag.

Characters arrive on a valid/ready input together with a flag that marks the final character. Clauses leave on a valid/ready output. Each clause is built from three consecutive literals, and a short final clause is filled out with space literals. While a clause waits at the output, the input is stalled. A free-running clause count and a one-cycle done pulse let the surrounding logic track progress.

Top module: `sig_clause_enc`

## Requirements
- R1: Upper and lower case forms of a letter produce the same literal.
- R2: Letters are numbered from zero, so a is 0 and z is 25. Letter number k gives variable k/2+1 (integer division). The negate bit is set when k is odd. This maps a to u1, b to not-u1, and so on up to z as not-u13.
- R3: A space gives variable 14 with the negate bit clear.
- R4: A clause holds three literals from consecutive characters in input order. The first literal appears on out_var[3:0] and out_neg[0], the second on out_var[7:4] and out_neg[1], and the third on out_var[11:8] and out_neg[2].
- R5: If the final character (in_last set) leaves a clause with only one or two literals, the remaining slots are filled with the space literal (variable 14, not negated) and the clause is emitted.
- R6: A character that is neither a letter nor a space is accepted but yields no literal. It sets err_sticky, which stays high until reset.
- R7: While out_valid is high, in_ready is low. The clause on the outputs stays unchanged until out_ready is sampled high.
- R8: clause_count increases by one on each output handshake.
- R9: done is high for exactly one cycle. It follows the handshake of a clause that contains the final character. It also follows the acceptance of an invalid final character when no literals are pending, and in that case no clause is produced.
- R10: A synchronous active-high reset discards any partially formed clause and clears out_valid, err_sticky, clause_count and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Character accepted this cycle when in_valid is high |
| in_char | input | 8 | Character code |
| in_last | input | 1 | Marks the final character of the signature |
| out_valid | output | 1 | Clause available |
| out_ready | input | 1 | Consumer takes the clause |
| out_var | output | 12 | Three 4-bit variable numbers, first literal in the low bits |
| out_neg | output | 3 | Negate bit for each literal, first literal in bit 0 |
| err_sticky | output | 1 | An invalid character has been seen since reset |
| clause_count | output | 16 | Clauses handed over since reset |
| done | output | 1 | One-cycle end-of-signature pulse |

## Verification
The hardest case to reach is an invalid final character that arrives when no literals are pending. No clause is formed in that case, so done has to come from the input side rather than from an output handshake. The bench reaches it by sending a complete three-letter clause, draining it, and then offering a single invalid character with the final flag set. The bench also holds out_ready low for several cycles while a character is offered. This shows that the stalled character is neither lost nor taken early. It also resets the block halfway through a clause to show that the half-built literals are dropped.

// File: rtl/sig_clause_pkg.sv
package sig_clause_pkg;

    localparam int LPC       = 3;
    localparam int VAR_W     = 4;
    localparam int SPACE_VAR = 14;
    localparam int FILL_W    = $clog2(LPC + 1);

    typedef struct packed {
        logic [VAR_W-1:0] vnum;
        logic             neg;
    } lit_t;

    typedef struct packed {
        logic ok;
        lit_t lit;
    } dec_t;

    function automatic lit_t space_lit();
        lit_t r;
        r.vnum = VAR_W'(SPACE_VAR);
        r.neg  = 1'b0;
        return r;
    endfunction

    function automatic dec_t decode_char(input logic [7:0] ch);
        dec_t       r;
        logic [7:0] low;
        logic [4:0] k;
        r   = '0;
        low = ch | 8'h20;
        k   = 5'(low - 8'h61);
        if (ch == 8'h20) begin
            r.ok  = 1'b1;
            r.lit = space_lit();
        end else if (low >= 8'h61 && low <= 8'h7a) begin
            r.ok       = 1'b1;
            r.lit.vnum = VAR_W'(k[4:1]) + VAR_W'(1);
            r.lit.neg  = k[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/sig_char_decoder.sv
module sig_char_decoder
    import sig_clause_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] ch_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = decode_char(8'(ch_i));
    end
endmodule

// File: rtl/sig_clause_assembler.sv
module sig_clause_assembler
    import sig_clause_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_i,
    input  dec_t           dec_i,
    input  logic           last_i,
    input  logic           out_ready_i,
    output logic           out_valid_o,
    output lit_t [LPC-1:0] held_o,
    output logic           hs_o,
    output logic           final_hs_o,
    output logic           empty_last_o,
    output logic           err_o
);
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] fill_after;
    lit_t [LPC-1:0]    part;
    lit_t [LPC-1:0]    merged;
    lit_t [LPC-1:0]    padded;
    logic              fin;
    logic              emit;

    always_comb begin
        merged = part;
        if (dec_i.ok) merged[fill] = dec_i.lit;
        fill_after = fill + FILL_W'(dec_i.ok);
        for (int i = 0; i < LPC; i++) begin
            padded[i] = (FILL_W'(i) < fill_after) ? merged[i] : space_lit();
        end
        emit = acc_i && ((dec_i.ok && fill == FILL_W'(LPC - 1)) ||
                         (last_i && fill_after != '0));
    end

    assign hs_o         = out_valid_o && out_ready_i;
    assign final_hs_o   = hs_o && fin;
    assign empty_last_o = acc_i && last_i && !emit;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill        <= '0;
            part        <= '0;
            held_o      <= '0;
            out_valid_o <= 1'b0;
            fin         <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            if (hs_o) out_valid_o <= 1'b0;
            if (acc_i && !dec_i.ok) err_o <= 1'b1;
            if (acc_i) begin
                if (emit) begin
                    held_o      <= padded;
                    out_valid_o <= 1'b1;
                    fin         <= last_i;
                    fill        <= '0;
                end else if (last_i) begin
                    fill <= '0;
                end else if (dec_i.ok) begin
                    part <= merged;
                    fill <= fill_after;
                end
            end
        end
    end

    // R7: a held clause stays put until taken
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(held_o));

    // R4: never more than LPC-1 literals pending
    p_fill_range_r4: assert property (@(posedge clk) disable iff (rst)
        fill < FILL_W'(LPC));

    // R6: error flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R5: no clause ever carries an empty slot
    generate
        for (genvar gi = 0; gi < LPC; gi++) begin : g_rng
            p_var_range_r5: assert property (@(posedge clk) disable iff (rst)
                out_valid_o |-> (held_o[gi].vnum >= VAR_W'(1) &&
                                 held_o[gi].vnum <= VAR_W'(SPACE_VAR)));
        end
    endgenerate
endmodule

// File: rtl/sig_progress_tracker.sv
module sig_progress_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_i,
    input  logic             final_hs_i,
    input  logic             empty_last_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            done_o  <= 1'b0;
        end else begin
            if (hs_i) count_o <= count_o + CNT_W'(1);
            done_o <= final_hs_i || empty_last_i;
        end
    end

    // R8: one step per handshake
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        hs_i |=> count_o == $past(count_o) + CNT_W'(1));

    // R9: done never lasts two cycles
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/sig_clause_enc.sv
module sig_clause_enc
    import sig_clause_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CHAR_W-1:0]    in_char,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [LPC*VAR_W-1:0] out_var,
    output logic [LPC-1:0]       out_neg,
    output logic                 err_sticky,
    output logic [CNT_W-1:0]     clause_count,
    output logic                 done
);
    dec_t           dec;
    lit_t [LPC-1:0] held;
    logic           acc, hs, final_hs, empty_last;

    assign in_ready = !out_valid;
    assign acc      = in_valid && in_ready;

    sig_char_decoder #(.CHAR_W(CHAR_W)) u_dec (
        .ch_i  (in_char),
        .dec_o (dec)
    );

    sig_clause_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .acc_i        (acc),
        .dec_i        (dec),
        .last_i       (in_last),
        .out_ready_i  (out_ready),
        .out_valid_o  (out_valid),
        .held_o       (held),
        .hs_o         (hs),
        .final_hs_o   (final_hs),
        .empty_last_o (empty_last),
        .err_o        (err_sticky)
    );

    sig_progress_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk          (clk),
        .rst          (rst),
        .hs_i         (hs),
        .final_hs_i   (final_hs),
        .empty_last_i (empty_last),
        .count_o      (clause_count),
        .done_o       (done)
    );

    generate
        for (genvar gi = 0; gi < LPC; gi++) begin : g_out
            assign out_var[gi*VAR_W +: VAR_W] = held[gi].vnum;
            assign out_neg[gi]                = held[gi].neg;
        end
    endgenerate

    // R7: input is refused while a clause is held
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> !in_ready);
endmodule

// File: tb/sig_clause_enc_tb.sv
`timescale 1ns/1ps
module sig_clause_enc_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_last, out_valid, out_ready;
    logic [7:0]  in_char;
    logic [11:0] out_var;
    logic [2:0]  out_neg;
    logic        err_sticky, done;
    logic [15:0] clause_count;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sig_clause_enc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_char(in_char), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_var(out_var), .out_neg(out_neg),
        .err_sticky(err_sticky), .clause_count(clause_count), .done(done)
    );

    // {last, char} for "cat dog fox"
    localparam logic [8:0] STIM [11] = '{
        {1'b0,8'h63},{1'b0,8'h61},{1'b0,8'h74},{1'b0,8'h20},{1'b0,8'h64},
        {1'b0,8'h6f},{1'b0,8'h67},{1'b0,8'h20},{1'b0,8'h66},{1'b0,8'h6f},
        {1'b1,8'h78}};
    // {neg[2:0], var[11:0]}
    localparam logic [14:0] EXPC [4] = '{
        {3'b100,12'hA12},{3'b010,12'h82E},{3'b100,12'h3E4},{3'b010,12'hEC8}};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] ch, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_char = ch; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic take(input string tag, input logic [14:0] exp,
                        input int delay, input logic exp_done, input logic [15:0] exp_cnt);
        int n = 0;
        while (!out_valid && n < 100) begin @(negedge clk); n++; end
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " clause"}, 32'({out_neg, out_var}), 32'(exp));
        for (int d = 0; d < delay; d++) begin
            @(negedge clk);
            check("R7 held", 32'({out_valid, in_ready, out_neg, out_var}), 32'({2'b10, exp}));
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        check({tag, " R9 done"}, 32'(done), 32'(exp_done));
        check({tag, " R8 count"}, 32'(clause_count), 32'(exp_cnt));
        if (exp_done) begin
            @(negedge clk);
            check("R9 done one cycle", 32'(done), 32'd0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_char = '0; in_last = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R10 reset state
        check("R10 reset", 32'({in_ready, out_valid, err_sticky, done, clause_count}), 32'h80000);

        // R2 R3 R4 R5: table walk
        begin
            int k = 0;
            for (int i = 0; i < 11; i++) begin
                send(STIM[i][7:0], STIM[i][8]);
                if (i % 3 == 2 || STIM[i][8]) begin
                    take("R4 table", EXPC[k], 0, STIM[i][8], 16'(k + 1));
                    k++;
                end
            end
        end

        // R1 mixed case
        send(8'h41, 0); send(8'h62, 0); send(8'h5a, 0);
        take("R1 case", {3'b110, 12'hD11}, 0, 1'b0, 16'd5);

        // R5 single char padded with two spaces
        send(8'h59, 1);
        take("R5 pad", {3'b000, 12'hEED}, 0, 1'b1, 16'd6);

        // R6 invalid char dropped, sticky flag
        check("R6 no err yet", 32'(err_sticky), 32'd0);
        send(8'h61, 0); send(8'h23, 0);
        check("R6 err set", 32'(err_sticky), 32'd1);
        send(8'h62, 1);
        take("R6 drop", {3'b010, 12'hE11}, 0, 1'b1, 16'd7);

        // R7 backpressure with a char offered during the hold
        send(8'h61, 0); send(8'h62, 0); send(8'h63, 0);
        @(negedge clk);
        in_valid = 1'b1; in_char = 8'h23; in_last = 1'b1;
        take("R7 stall", {3'b010, 12'h211}, 5, 1'b0, 16'd8);
        // R9 invalid final char with nothing pending: taken now
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R9 empty-last done", 32'(done), 32'd1);
        check("R9 no clause", 32'({out_valid, clause_count}), 32'h00008);
        @(negedge clk);
        check("R9 done cleared", 32'(done), 32'd0);
        check("R6 still sticky", 32'(err_sticky), 32'd1);

        // R10 reset mid-clause
        send(8'h61, 0); send(8'h62, 0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R10 cleared", 32'({out_valid, err_sticky, clause_count}), 32'h0);
        send(8'h63, 0); send(8'h64, 0); send(8'h65, 0);
        take("R10 fresh", {3'b010, 12'h322}, 0, 1'b0, 16'd1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule